// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Single-Byte Buffers

This block is a small asynchronous serial port attached to a simple register bus. The bus carries an address, a write strobe, a read strobe, write data and registered read data. Software loads one transmit byte at a time into a holding register. The transmitter moves that byte into a shift register and sends it as a fixed frame: a low start bit, eight data bits with the least significant bit first, and one high stop bit. There is no parity. The receiver watches the incoming line for a falling edge and confirms the start bit at its midpoint. It then samples every data bit at its centre and places a good frame into a one-byte receive register.

The bit time is a raw count of clock cycles taken from a divider register. Any count below sixteen is raised to sixteen. Four events are recorded in sticky flags that software clears by writing ones:
- the transmit buffer has freed up;
- a byte has been received;
- a transmit write was lost;
- a receive byte was lost.

Each flag has its own enable bit. The enabled flags drive a transmit line, a receive line, an overrun line shared by both overrun causes, and one combined line that is the OR of every enabled cause.

Top module: `sio_periph`

## Requirements
- R1: After reset, every register reads zero, the serial output `txd` is high, and all four interrupt outputs are low.
- R2: Registers sit at these byte offsets: data 0x00, status 0x04, control 0x08, flags 0x0C, divider 0x10. Control keeps only bits 5:0 and the divider keeps only bits 20:0. A read from any other offset returns zero. Read data appears on `bus_rdata` one clock after the read strobe.
- R3: When control bit 0 (transmit enable) is set, a byte in the transmit holding register is sent on `txd` as one low start bit, eight data bits LSB first and one high stop bit. Each bit lasts the effective divider count in clocks. While control bit 0 is clear, the byte stays held and `txd` stays high.
- R4: A write to data while status bit 0 (transmit full) is clear stores the byte and sets status bit 0. When the byte moves into the shifter, status bit 0 clears and flag bit 0 sets.
- R5: A write to data while status bit 0 is set discards the new byte. It sets flag bit 2, which also reads as status bit 2, and the held byte is the one later sent.
- R6: With control bit 1 (receive enable) set, the receiver does the following:
  - it detects a falling edge on `rxd`;
  - it checks that the line is still low half a bit later;
  - it samples eight bits at their midpoints, LSB first;
  - if the stop bit is high, it puts the byte in the receive register, sets status bit 1 and flag bit 1.
  A read of data returns that byte and clears status bit 1.
- R7: A frame whose stop bit is low is dropped. Status bit 1 and flag bit 1 are left unchanged.
- R8: A good frame that arrives while status bit 1 is set leaves the receive register holding the older byte. It sets flag bit 3, which also reads as status bit 3.
- R9: Writing the flags register clears each flag whose written bit is 1 and leaves flags written with 0 unchanged. A flag set in the same cycle as its clear stays set.
- R10: Interrupt outputs are registered one clock after the flags. They behave as follows:
  - `irq_tx` is flag 0 gated by control bit 2;
  - `irq_rx` is flag 1 gated by control bit 3;
  - `irq_ovr` is flag 2 gated by control bit 4, ORed with flag 3 gated by control bit 5;
  - `irq_any` is the OR of all four gated causes.
- R11: The effective bit time is the divider value, or 16 when the divider is below 16.
- R12: While control bit 1 is clear, activity on `rxd` is ignored and no byte is received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Registered read data |
| rxd | input | 1 | Serial input line |
| txd | output | 1 | Serial output line, idles high |
| irq_tx | output | 1 | Transmit-buffer-free interrupt |
| irq_rx | output | 1 | Byte-received interrupt |
| irq_ovr | output | 1 | Either overrun interrupt |
| irq_any | output | 1 | OR of all enabled causes |

## Verification
Some rules are checked by the assertions on every clock:
- `txd` is high whenever the shifter is idle;
- the transmit flag only rises as the holding byte leaves;
- a receive overrun never disturbs the stored byte;
- a written-one clear removes the receive flag;
- the received-byte pulse lasts one cycle and never appears while receive is off.

Frame shape, bit timing, the divider minimum, LSB-first order, dropping of bad stop bits, and the gating of each interrupt line by its enable bit are shown only by the bench's directed scenarios. The bench decodes `txd` itself and drives `rxd` itself to check these.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int OFF_DATA = 'h00;
  localparam int OFF_STAT = 'h04;
  localparam int OFF_CTRL = 'h08;
  localparam int OFF_FLAG = 'h0C;
  localparam int OFF_DIV  = 'h10;

  localparam int C_TXEN  = 0;
  localparam int C_RXEN  = 1;
  localparam int C_IE_LO = 2;
  localparam int CTRL_W  = 6;

  localparam int F_TX  = 0;
  localparam int F_RX  = 1;
  localparam int F_TXO = 2;
  localparam int F_RXO = 3;
  localparam int NFLAG = 4;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP} rx_state_t;
endpackage

// File: rtl/sio_tx.sv
module sio_tx #(
  parameter int DW    = 8,
  parameter int DIV_W = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DW-1:0]    din,
  input  logic [DIV_W-1:0] bit_cycles,
  output logic             busy,
  output logic             txd
);
  localparam int NSH = DW + 1;
  localparam int CW  = $clog2(NSH + 1);

  logic [NSH-1:0]   shreg;
  logic [CW-1:0]    nleft;
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      txd   <= 1'b1;
      shreg <= '1;
      nleft <= '0;
      cnt   <= '0;
    end else if (!busy) begin
      if (load) begin
        busy  <= 1'b1;
        txd   <= 1'b0;
        shreg <= {1'b1, din};
        nleft <= CW'(NSH);
        cnt   <= bit_cycles - DIV_W'(1);
      end
    end else if (cnt == '0) begin
      if (nleft == '0) begin
        busy <= 1'b0;
        txd  <= 1'b1;
      end else begin
        txd   <= shreg[0];
        shreg <= {1'b1, shreg[NSH-1:1]};
        nleft <= nleft - CW'(1);
        cnt   <= bit_cycles - DIV_W'(1);
      end
    end else begin
      cnt <= cnt - DIV_W'(1);
    end
  end

  AST_TXD_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd); // R1
endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DIV_W = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             rxd,
  input  logic [DIV_W-1:0] bit_cycles,
  output logic             valid,
  output logic [DW-1:0]    data
);
  localparam int IW = (DW > 1) ? $clog2(DW) : 1;

  logic             s1, s2, s3;
  rx_state_t        state;
  logic [DIV_W-1:0] cnt;
  logic [IW-1:0]    idx;
  logic [DIV_W-1:0] half;

  assign half = bit_cycles >> 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= rxd;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RX_IDLE;
      cnt   <= '0;
      idx   <= '0;
      data  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (!en) begin
        state <= RX_IDLE;
      end else begin
        case (state)
          RX_IDLE: if (s3 && !s2) begin
            state <= RX_START;
            cnt   <= half - DIV_W'(1);
          end
          RX_START: if (cnt == '0) begin
            if (!s2) begin
              state <= RX_BITS;
              idx   <= '0;
              cnt   <= bit_cycles - DIV_W'(1);
            end else begin
              state <= RX_IDLE;
            end
          end else cnt <= cnt - DIV_W'(1);
          RX_BITS: if (cnt == '0) begin
            data <= {s2, data[DW-1:1]};
            cnt  <= bit_cycles - DIV_W'(1);
            if (idx == IW'(DW - 1)) state <= RX_STOP;
            else idx <= idx + IW'(1);
          end else cnt <= cnt - DIV_W'(1);
          default: if (cnt == '0) begin
            valid <= s2;
            state <= RX_IDLE;
          end else cnt <= cnt - DIV_W'(1);
        endcase
      end
    end
  end

  AST_RX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid); // R6
  AST_RX_SILENT_OFF: assert property (@(posedge clk) disable iff (rst)
    !en |=> !valid); // R12
endmodule

// File: rtl/sio_irq.sv
module sio_irq #(
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] flags,
  input  logic [NF-1:0] enables,
  output logic          irq_tx,
  output logic          irq_rx,
  output logic          irq_ovr,
  output logic          irq_any
);
  logic [NF-1:0] gated;
  assign gated = flags & enables;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_tx  <= 1'b0;
      irq_rx  <= 1'b0;
      irq_ovr <= 1'b0;
      irq_any <= 1'b0;
    end else begin
      irq_tx  <= gated[0];
      irq_rx  <= gated[1];
      irq_ovr <= |gated[NF-1:2];
      irq_any <= |gated;
    end
  end
endmodule

// File: rtl/sio_periph.sv
module sio_periph
  import sio_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int BUS_W   = 32,
  parameter int DIV_W   = 21,
  parameter int DIV_MIN = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              rxd,
  output logic              txd,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              irq_ovr,
  output logic              irq_any
);
  localparam int DW = 8;

  logic [CTRL_W-1:0] ctrl;
  logic [DIV_W-1:0]  baud_div;
  logic [DIV_W-1:0]  bit_cycles;
  logic [NFLAG-1:0]  flags, flag_set, flag_clr;
  logic [DW-1:0]     tx_hold, rx_buf, rx_data;
  logic              tx_full, rx_full, tx_busy, tx_load, rx_valid;
  logic              wr_data, rd_data, wr_flag, rx_accept;
  logic              wdata_unused;

  assign wdata_unused = ^bus_wdata[BUS_W-1:DIV_W];

  assign wr_data = bus_wr && (bus_addr == ADDR_W'(OFF_DATA));
  assign wr_flag = bus_wr && (bus_addr == ADDR_W'(OFF_FLAG));
  assign rd_data = bus_rd && (bus_addr == ADDR_W'(OFF_DATA));

  assign bit_cycles = (baud_div < DIV_W'(DIV_MIN)) ? DIV_W'(DIV_MIN) : baud_div;
  assign tx_load    = ctrl[C_TXEN] && tx_full && !tx_busy;
  assign rx_accept  = rx_valid && !rx_full;

  always_comb begin
    flag_set        = '0;
    flag_set[F_TX]  = tx_load;
    flag_set[F_RX]  = rx_accept;
    flag_set[F_TXO] = wr_data && tx_full;
    flag_set[F_RXO] = rx_valid && rx_full;
    flag_clr        = wr_flag ? bus_wdata[NFLAG-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '0;
      baud_div <= '0;
      flags    <= '0;
      tx_hold  <= '0;
      tx_full  <= 1'b0;
      rx_buf   <= '0;
      rx_full  <= 1'b0;
    end else begin
      flags <= (flags & ~flag_clr) | flag_set;
      if (bus_wr && bus_addr == ADDR_W'(OFF_CTRL)) ctrl <= bus_wdata[CTRL_W-1:0];
      if (bus_wr && bus_addr == ADDR_W'(OFF_DIV))  baud_div <= bus_wdata[DIV_W-1:0];
      if (wr_data && !tx_full) begin
        tx_hold <= bus_wdata[DW-1:0];
        tx_full <= 1'b1;
      end else if (tx_load) begin
        tx_full <= 1'b0;
      end
      if (rx_accept) begin
        rx_buf  <= rx_data;
        rx_full <= 1'b1;
      end else if (rd_data) begin
        rx_full <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        ADDR_W'(OFF_DATA): bus_rdata <= BUS_W'(rx_buf);
        ADDR_W'(OFF_STAT): bus_rdata <= BUS_W'({flags[F_RXO], flags[F_TXO], rx_full, tx_full});
        ADDR_W'(OFF_CTRL): bus_rdata <= BUS_W'(ctrl);
        ADDR_W'(OFF_FLAG): bus_rdata <= BUS_W'(flags);
        ADDR_W'(OFF_DIV):  bus_rdata <= BUS_W'(baud_div);
        default:           bus_rdata <= '0;
      endcase
    end
  end

  sio_tx #(.DW(DW), .DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst(rst), .load(tx_load), .din(tx_hold),
    .bit_cycles(bit_cycles), .busy(tx_busy), .txd(txd)
  );

  sio_rx #(.DW(DW), .DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst(rst), .en(ctrl[C_RXEN]), .rxd(rxd),
    .bit_cycles(bit_cycles), .valid(rx_valid), .data(rx_data)
  );

  sio_irq #(.NF(NFLAG)) u_irq (
    .clk(clk), .rst(rst), .flags(flags),
    .enables(ctrl[C_IE_LO +: NFLAG]),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_ovr(irq_ovr), .irq_any(irq_any)
  );

  AST_TX_FLAG_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[F_TX]) |-> ($past(tx_full) && !tx_full)); // R4
  AST_RX_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_full && !rd_data) |=> (rx_full && $stable(rx_buf))); // R8
  AST_W1C_RX_FLAG: assert property (@(posedge clk) disable iff (rst)
    (wr_flag && bus_wdata[F_RX] && !rx_valid) |=> !flags[F_RX]); // R9
endmodule

// File: tb/sio_periph_test.sv
module sio_periph_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rxd = 1'b1;
  logic        txd, irq_tx, irq_rx, irq_ovr, irq_any;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  localparam logic [4:0] A_DATA = 5'h00, A_STAT = 5'h04, A_CTRL = 5'h08,
                         A_FLAG = 5'h0C, A_DIV = 5'h10;

  always #10 clk = ~clk;

  sio_periph uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rxd(rxd), .txd(txd),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_ovr(irq_ovr), .irq_any(irq_any)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Decode one frame from txd; returns start-bit width in clocks
  task automatic grab_tx(input int eff, output logic [7:0] b, output int w, output bit stop_ok);
    int guard = 0;
    b = '0; w = 0; stop_ok = 1'b0;
    while (txd === 1'b1 && guard < 5000) begin @(negedge clk); guard++; end
    while (txd === 1'b0 && w < 5000) begin w++; @(negedge clk); end
    repeat (eff / 2) @(negedge clk);
    b[0] = txd;
    for (int i = 1; i < 8; i++) begin
      repeat (eff) @(negedge clk);
      b[i] = txd;
    end
    repeat (eff) @(negedge clk);
    stop_ok = txd;
    repeat (eff) @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] b, input logic stop, input int eff);
    @(negedge clk);
    rxd = 1'b0;
    repeat (eff) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (eff) @(negedge clk);
    end
    rxd = stop;
    repeat (eff) @(negedge clk);
    rxd = 1'b1;
    repeat (eff) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk(txd === 1'b1, "R1 txd idle", txd, 1);
    chk({irq_tx, irq_rx, irq_ovr, irq_any} === 4'b0, "R1 irqs low",
        {irq_tx, irq_rx, irq_ovr, irq_any}, 0);
    rd(A_DATA, v); chk(v == 0, "R1 data", v, 0);
    rd(A_STAT, v); chk(v == 0, "R1 status", v, 0);
    rd(A_CTRL, v); chk(v == 0, "R1 control", v, 0);
    rd(A_FLAG, v); chk(v == 0, "R1 flags", v, 0);
    rd(A_DIV, v);  chk(v == 0, "R1 divider", v, 0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    wr(A_CTRL, 32'hFFFF_FFC0); rd(A_CTRL, v); chk(v == 0, "R2 ctrl upper ignored", v, 0);
    wr(A_DIV, 32'hFFFF_FFFF); rd(A_DIV, v); chk(v == 32'h1F_FFFF, "R2 divider width", v, 32'h1F_FFFF);
    rd(5'h14, v); chk(v == 0, "R2 unmapped", v, 0);
    wr(A_DIV, 20);
  endtask

  task automatic t_tx_basic;
    logic [31:0] v; logic [7:0] b; int w; bit s;
    wr(A_CTRL, 32'h1);
    wr(A_DATA, 32'hA5);
    grab_tx(20, b, w, s);
    chk(b == 8'hA5, "R3 tx byte", b, 8'hA5);
    chk(w == 20, "R3 bit time", w, 20);
    chk(s, "R3 stop bit high", s, 1);
    rd(A_STAT, v); chk(v[0] == 1'b0, "R4 tx full cleared", v[0], 0);
    rd(A_FLAG, v); chk(v[0] == 1'b1, "R4 tx flag set", v[0], 1);
    wr(A_FLAG, 32'hF);
  endtask

  task automatic t_tx_overrun;
    logic [31:0] v; logic [7:0] b; int w; bit s; bit stayed = 1'b1;
    wr(A_CTRL, 32'h0);
    wr(A_DATA, 32'h3D);
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (txd !== 1'b1) stayed = 1'b0; end
    chk(stayed, "R3 disabled tx stays high", stayed, 1);
    rd(A_STAT, v); chk(v[0] == 1'b1, "R4 tx full set", v[0], 1);
    wr(A_DATA, 32'hC3);
    rd(A_STAT, v); chk(v[2] == 1'b1, "R5 status tx overrun", v[2], 1);
    wr(A_FLAG, 32'h0);
    rd(A_FLAG, v); chk(v[2] == 1'b1, "R9 write zero keeps flag", v[2], 1);
    wr(A_CTRL, 32'h1);
    grab_tx(20, b, w, s);
    chk(b == 8'h3D, "R5 held byte sent", b, 8'h3D);
    wr(A_FLAG, 32'hF);
    rd(A_FLAG, v); chk(v == 0, "R9 write ones clears", v, 0);
  endtask

  task automatic t_min_div;
    logic [7:0] b; int w; bit s;
    wr(A_DIV, 5);
    wr(A_DATA, 32'h01);
    grab_tx(16, b, w, s);
    chk(w == 16, "R11 minimum bit time", w, 16);
    chk(b == 8'h01, "R11 byte at minimum rate", b, 1);
    wr(A_DIV, 20);
    wr(A_FLAG, 32'hF);
  endtask

  task automatic t_rx;
    logic [31:0] v;
    wr(A_CTRL, 32'h2);
    send_rx(8'h5A, 1'b1, 20);
    rd(A_STAT, v); chk(v[1] == 1'b1, "R6 rx full", v[1], 1);
    rd(A_FLAG, v); chk(v[1] == 1'b1, "R6 rx flag", v[1], 1);
    rd(A_DATA, v); chk(v == 32'h5A, "R6 rx byte LSB first", v, 32'h5A);
    rd(A_STAT, v); chk(v[1] == 1'b0, "R6 read clears full", v[1], 0);
    wr(A_FLAG, 32'hF);
    send_rx(8'h77, 1'b0, 20);
    rd(A_STAT, v); chk(v[1] == 1'b0, "R7 bad stop dropped", v[1], 0);
    rd(A_FLAG, v); chk(v[1] == 1'b0, "R7 no rx flag", v[1], 0);
  endtask

  task automatic t_rx_overrun;
    logic [31:0] v;
    send_rx(8'h11, 1'b1, 20);
    send_rx(8'h22, 1'b1, 20);
    rd(A_STAT, v); chk(v[3] == 1'b1, "R8 status rx overrun", v[3], 1);
    rd(A_FLAG, v); chk(v[3] == 1'b1, "R8 flag rx overrun", v[3], 1);
    rd(A_DATA, v); chk(v == 32'h11, "R8 older byte kept", v, 32'h11);
    wr(A_FLAG, 32'hF);
  endtask

  task automatic t_rx_off;
    logic [31:0] v;
    wr(A_CTRL, 32'h0);
    send_rx(8'h99, 1'b1, 20);
    rd(A_STAT, v); chk(v[1] == 1'b0, "R12 rx disabled ignores line", v[1], 0);
    rd(A_FLAG, v); chk(v[1] == 1'b0, "R12 no rx flag", v[1], 0);
  endtask

  task automatic t_irq;
    logic [31:0] v; logic [7:0] b; int w; bit s;
    wr(A_CTRL, 32'h0A);
    wr(A_FLAG, 32'hF);
    send_rx(8'h66, 1'b1, 20);
    idle(3);
    chk(irq_rx === 1'b1, "R10 irq_rx", irq_rx, 1);
    chk(irq_any === 1'b1, "R10 irq_any from rx", irq_any, 1);
    chk(irq_tx === 1'b0 && irq_ovr === 1'b0, "R10 other lines low", {irq_tx, irq_ovr}, 0);
    wr(A_FLAG, 32'h2);
    idle(2);
    chk(irq_rx === 1'b0 && irq_any === 1'b0, "R10 cleared rx irq", {irq_rx, irq_any}, 0);
    rd(A_DATA, v);
    wr(A_CTRL, 32'h02);
    wr(A_DATA, 32'h81);
    wr(A_DATA, 32'h42);
    idle(2);
    chk(irq_ovr === 1'b0 && irq_any === 1'b0, "R10 overrun gated off", {irq_ovr, irq_any}, 0);
    wr(A_CTRL, 32'h12);
    idle(2);
    chk(irq_ovr === 1'b1 && irq_any === 1'b1, "R10 overrun enabled", {irq_ovr, irq_any}, 3);
    wr(A_FLAG, 32'h4);
    idle(2);
    chk(irq_ovr === 1'b0, "R10 overrun cleared", irq_ovr, 0);
    wr(A_CTRL, 32'h05);
    idle(3);
    chk(irq_tx === 1'b1 && irq_any === 1'b1, "R10 irq_tx on buffer free", {irq_tx, irq_any}, 3);
    grab_tx(20, b, w, s);
    chk(b == 8'h81, "R5 first byte kept under irq test", b, 8'h81);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_tx_basic();
    t_tx_overrun();
    t_min_div();
    t_rx();
    t_rx_overrun();
    t_rx_off();
    t_irq();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule